// File: doc/BRIEF.md
# Bank of 32 General-Purpose Pins with Atomic Output Update

This block is a 32-pin general-purpose I/O bank controlled through a small word-addressed register bus. Firmware sets each pin's direction, changes output levels without a read-modify-write, and reads back what is actually present on the pins. Each pin's output-enable and output-value signals go to the pad ring. Each pin input comes back through a two-stage clock synchronizer.

The output latch can be written in three ways. A direct write replaces the whole latch. A write to the set port raises every bit that is one in the written word. A write to the clear port lowers every bit that is one in the written word. The bus accepts at most one write per cycle, so a set and a clear aimed at the same bit are applied in the order they were issued. Reads are combinational and have no side effects.

Top module: `gpio_bank`

## Requirements
- R1: When reset is released, the direction register holds all ones (every pin is an input), the output latch holds all zeros, `pin_oe` is all zeros and `pin_out` is all zeros.
- R2: Word offset 0 is the direction register. A bit value of 1 makes that pin an input and 0 makes it an output. Bit n of a register always belongs to pin n. One cycle after a write to offset 0, `pin_oe` equals the bitwise inverse of the written word.
- R3: A write to word offset 2 (set port) ORs the written word into the output latch. Zero bits leave the latch bits unchanged.
- R4: A write to word offset 3 (clear port) clears every latch bit where the written word has a one. Zero bits leave the latch bits unchanged.
- R5: Word offset 1 holds the output latch. Reading it returns the latch, and writing it replaces the whole latch. `pin_out` always equals the latch, whatever the direction.
- R6: Reading word offset 4 returns the pin levels through a two-flip-flop synchronizer, in either direction. A change on `pin_in` becomes visible on the second rising clock edge after it occurs, so a read taken after only one edge still returns the old level.
- R7: The output latch changes only on a write to offset 1, 2 or 3. Writes to offsets 4 through 7 change neither the latch nor the direction register.
- R8: Reads of offsets 2, 3, 5, 6 and 7 return zero. `rdata` reflects `addr` in the same cycle and has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | 3 | Word offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |
| pin_out | output | 32 | Per-pin output value |

## Verification
The properties assume that `wr_en`, `addr` and `wdata` are synchronous to `clk` and stable around the rising edge. The synchronizer-latency property also assumes that `pin_in` changes only away from the edge, so the two-edge delay is exact rather than one edge plus metastability. The stimulus drives every input on the falling edge and holds each pin pattern for several cycles. Bus writes use random data across all eight offsets, so the unmapped offsets and the read-only input offset receive writes as well.

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int WIDTH       = 32,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_oe,
  output logic [WIDTH-1:0] pin_out
);

  localparam logic [AW-1:0] OFS_DIR = AW'(0);
  localparam logic [AW-1:0] OFS_OUT = AW'(1);
  localparam logic [AW-1:0] OFS_SET = AW'(2);
  localparam logic [AW-1:0] OFS_CLR = AW'(3);
  localparam logic [AW-1:0] OFS_IN  = AW'(4);

  logic [WIDTH-1:0] dir_q, out_q;
  logic [WIDTH-1:0] sync_q [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (wr_en) begin
      case (addr)
        OFS_DIR: dir_q <= wdata;
        OFS_OUT: out_q <= wdata;
        OFS_SET: out_q <= out_q | wdata;
        OFS_CLR: out_q <= out_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  always_comb begin
    case (addr)
      OFS_DIR: rdata = dir_q;
      OFS_OUT: rdata = out_q;
      OFS_IN:  rdata = sync_q[SYNC_STAGES-1];
      default: rdata = '0;
    endcase
  end

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int WIDTH = 32,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pin_in,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_out
);

  logic [1:0] edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= '0;
    else if (edges != 2'd3) edges <= edges + 2'd1;
  end

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(0)) |=> (pin_oe == ~$past(wdata)));

  // R3
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> (pin_out == ($past(pin_out) | $past(wdata))));

  // R4
  clear_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(3)) |=> (pin_out == ($past(pin_out) & ~$past(wdata))));

  // R5
  direct_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(1)) |=> (pin_out == $past(wdata)));

  // R6
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edges >= 2'd2 && addr == AW'(4)) |-> (rdata == $past(pin_in, 2)));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == AW'(1) || addr == AW'(2) || addr == AW'(3))) |=> $stable(pin_out));

  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(0)) |=> $stable(pin_oe));

  // R8
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(2) || addr == AW'(3) || addr >= AW'(5)) |-> (rdata == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_oe, pin_out;

  int checks = 0, fails = 0;
  logic [31:0] m_dir, m_out, m_pin;

  gpio_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
                .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_dir;
      3'd1: return m_out;
      3'd4: return m_pin;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0;
    case (a)
      3'd0: m_dir = d;
      3'd1: m_out = d;
      3'd2: m_out = m_out | d;
      3'd3: m_out = m_out & ~d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic check_pins(input string req);
    @(negedge clk); #1;
    check({req, " oe"}, pin_oe, ~m_dir);
    check({req, " out"}, pin_out, m_out);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_dir = '1; m_out = '0; m_pin = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    check_pins("R1");
    rd(3'd0, 32'hFFFF_FFFF, "R1 dir");
    rd(3'd1, 32'h0, "R1 latch");

    // R2 direction
    wr(3'd0, 32'h0000_FF0F);
    check_pins("R2");
    rd(3'd0, 32'h0000_FF0F, "R2");

    // R3 set port, zero bits untouched
    wr(3'd2, 32'h8000_0001);
    wr(3'd2, 32'h0000_0100);
    check_pins("R3");
    rd(3'd1, 32'h8000_0101, "R3");

    // R4 clear port
    wr(3'd3, 32'h8000_0000);
    check_pins("R4");
    rd(3'd1, 32'h0000_0101, "R4");

    // R4 set then clear of same bit: later write wins
    wr(3'd2, 32'h0000_0010);
    wr(3'd3, 32'h0000_0010);
    rd(3'd1, 32'h0000_0101, "R4 order");

    // R5 direct write replaces, output follows latch even for input pins
    wr(3'd1, 32'hDEAD_BEEF);
    check_pins("R5");
    rd(3'd1, 32'hDEAD_BEEF, "R5");

    // R7 writes to offsets 4..7 are ignored
    wr(3'd4, 32'h1234_5678);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0);
    check_pins("R7");
    rd(3'd1, 32'hDEAD_BEEF, "R7 latch");
    rd(3'd0, m_dir, "R7 dir");

    // R8 unmapped reads return zero
    rd(3'd2, 32'h0, "R8 set");
    rd(3'd3, 32'h0, "R8 clr");
    rd(3'd6, 32'h0, "R8 ofs6");

    // R6 synchronizer lag: old value after one edge, new after two
    @(negedge clk) pin_in = 32'hA5A5_5A5A;
    repeat (3) @(posedge clk);
    m_pin = 32'hA5A5_5A5A;
    rd(3'd4, m_pin, "R6 settled");
    @(negedge clk) pin_in = 32'h0F0F_F0F0;
    rd(3'd4, 32'hA5A5_5A5A, "R6 one edge");
    rd(3'd4, 32'h0F0F_F0F0, "R6 two edges");
    m_pin = 32'h0F0F_F0F0;

    // R6 pin level read in either direction
    for (int k = 0; k < 20; k++) begin
      logic [31:0] v;
      v = $urandom;
      wr(3'd0, $urandom);
      @(negedge clk) pin_in = v;
      repeat (2) @(posedge clk);
      m_pin = v;
      rd(3'd4, v, "R6 random");
    end

    // Random mixed traffic: R2 R3 R4 R5 R7 R8
    for (int k = 0; k < 400; k++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom_range(0, 7));
      d = (k % 5 == 0) ? 32'hFFFF_FFFF : $urandom;
      wr(a, d);
      check_pins("R5 random");
      a = 3'($urandom_range(0, 7));
      rd(a, exp_read(a), "R8 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule